// File: doc/BRIEF.md
# Interpolating Table Gather with Pairwise Post-Add

This block is one pipeline stage of a lookup-table based signal path. Each cycle it receives a buffer of 32 complex 16-bit table entries and a buffer of 16 real 16-bit fractions. For each of 16 lanes it fetches two table entries through two independent index maps, a "left" map and a "right" map. It forms the linear interpolation `(left << shift) + (right - left) * fraction` on the real and imaginary parts separately. It then adds every even lane to the odd lane above it. The result is eight complex outputs, each component widened to a 48-bit accumulator word.

The caller arranges the maps so that, for every lane, the right entry is the table point next to the left one. Lanes that are summed together must belong to the same output term. The stage trusts this arrangement and does not check it. The result is registered once, with a valid flag that travels alongside it.

Top module: `lerp_pairsum`

## Requirements
- R1: A synchronous reset, sampled on the rising clock edge, clears `outValid` and every bit of `outRe` and `outIm` to zero. Inputs seen during reset have no effect.
- R2: Outside reset, `outValid` equals the `inValid` value sampled at the previous rising edge.
- R3: Index field i (i = 0..15) of `leftCtl` and of `rightCtl` occupies bits [5i+4:5i]. This is the 80-bit payload of three 32-bit words packed from bit 0, so field 6 straddles bits 31/32 and field 12 straddles bits 63/64. A field value k selects table entry k, with its real part at `lutBuf[32k+15:32k]` and its imaginary part at `lutBuf[32k+31:32k+16]`, both two's complement.
- R4: Lane i < 8 takes its fraction selector from nibble i (bits [4i+3:4i]) of `fracSelLo`. Lane i ≥ 8 takes it from nibble i-8 of `fracSelHi`. A selector value s picks the signed fraction `fracBuf[16s+15:16s]`.
- R5: Each lane value is `(L << shift) + (R - L) * F`, computed exactly in signed arithmetic and separately for the real and imaginary parts. Here L and R are the gathered left and right parts, F is the lane fraction and shift is `shiftAmt`.
- R6: Output lane j (j = 0..7) is the sum of lane values 2j and 2j+1. It appears in `outRe[48j+47:48j]` and `outIm[48j+47:48j]`, one clock after the inputs are sampled with `inValid` high.
- R7: For every shift in 0..15 and every input value, including full-scale entries of opposite sign, each output component is exact and sign-extended to the full 48 bits.
- R8: While `inValid` is low, `outRe` and `outIm` keep their previous values, whatever the other inputs do.
- R9: A table buffer of all zeros, sampled with `inValid` high, produces all-zero outputs for every shift, fraction and index map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Inputs of this cycle are to be processed |
| lutBuf | input | 1024 | 32 complex table entries, 32 bits each (imaginary above real) |
| leftCtl | input | 80 | Sixteen 5-bit left gather indices |
| rightCtl | input | 80 | Sixteen 5-bit right gather indices |
| fracBuf | input | 256 | 16 signed 16-bit fractions |
| fracSelLo | input | 32 | Fraction selector nibbles for lanes 0..7 |
| fracSelHi | input | 32 | Fraction selector nibbles for lanes 8..15 |
| shiftAmt | input | 4 | Left shift applied to the left operand, 0..15 |
| outValid | output | 1 | Registered valid flag |
| outRe | output | 384 | Eight 48-bit signed real sums |
| outIm | output | 384 | Eight 48-bit signed imaginary sums |

## Verification
The bench builds the block with its default parameters: 16 lanes, a 32-entry table, 16 fractions, a 4-bit shift and 48-bit outputs. A 32-entry table lets every index carry a distinct value, so any mis-routed field, including the two fields that cross word boundaries, shows up in the sums. A 4-bit shift reaches 15. Combined with full-scale entries of opposite sign and a full-scale fraction, this drives the pair sums close to the top of their 35-bit range, which exercises the sign extension.

// File: rtl/lerp_pkg.sv
package lerp_pkg;

  // Strobes passed from the control half to the datapath half
  typedef struct packed {
    logic capture;  // load the output registers with fresh sums
    logic clear;    // force the output registers to zero
  } lerpStrobe_t;

endpackage

// File: rtl/lerp_lane.sv
// One interpolation lane for one component (real or imaginary).
module lerp_lane #(
  parameter int SAMP_W  = 16,
  parameter int FRAC_W  = 16,
  parameter int SHIFT_W = 4,
  parameter int LANE_W  = 34
) (
  input  logic signed [SAMP_W-1:0]  leftVal,
  input  logic signed [SAMP_W-1:0]  rightVal,
  input  logic signed [FRAC_W-1:0]  frac,
  input  logic        [SHIFT_W-1:0] shiftAmt,
  output logic signed [LANE_W-1:0]  laneVal
);
  localparam int DIFF_W = SAMP_W + 1;
  localparam int PROD_W = DIFF_W + FRAC_W;

  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] diffExt, fracExt, prod;
  logic signed [LANE_W-1:0] leftExt, shifted, prodExt;

  // pre-subtraction keeps one extra bit so no difference wraps
  assign diff    = {rightVal[SAMP_W-1], rightVal} - {leftVal[SAMP_W-1], leftVal};
  assign diffExt = diff;
  assign fracExt = frac;
  assign prod    = diffExt * fracExt;
  assign prodExt = prod;

  assign leftExt = leftVal;
  assign shifted = leftExt <<< shiftAmt;

  assign laneVal = shifted + prodExt;

endmodule

// File: rtl/lerp_ctrl.sv
module lerp_ctrl
  import lerp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output lerpStrobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.clear   = rst;
    strobe.capture = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/lerp_datapath.sv
module lerp_datapath
  import lerp_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int TAB_DEPTH  = 32,
  parameter int SAMP_W     = 16,
  parameter int FRAC_DEPTH = 16,
  parameter int FRAC_W     = 16,
  parameter int SHIFT_W    = 4,
  parameter int ACC_W      = 48,
  localparam int IDX_W     = $clog2(TAB_DEPTH),
  localparam int SEL_W     = $clog2(FRAC_DEPTH),
  localparam int HALF      = LANES / 2,
  localparam int OUT_LANES = LANES / 2,
  localparam int ENTRY_W   = 2 * SAMP_W
) (
  input  logic                          clk,
  input  lerpStrobe_t                   strobe,
  input  logic [TAB_DEPTH*ENTRY_W-1:0]  lutBuf,
  input  logic [LANES*IDX_W-1:0]        leftCtl,
  input  logic [LANES*IDX_W-1:0]        rightCtl,
  input  logic [FRAC_DEPTH*FRAC_W-1:0]  fracBuf,
  input  logic [HALF*SEL_W-1:0]         fracSelLo,
  input  logic [HALF*SEL_W-1:0]         fracSelHi,
  input  logic [SHIFT_W-1:0]            shiftAmt,
  output logic [OUT_LANES*ACC_W-1:0]    outRe,
  output logic [OUT_LANES*ACC_W-1:0]    outIm
);
  localparam int SHIFT_MAX = (1 << SHIFT_W) - 1;
  localparam int SHL_W     = SAMP_W + SHIFT_MAX;
  localparam int PROD_W    = SAMP_W + 1 + FRAC_W;
  localparam int LANE_W    = ((SHL_W > PROD_W) ? SHL_W : PROD_W) + 1;

  logic signed [LANE_W-1:0] laneRe [LANES];
  logic signed [LANE_W-1:0] laneIm [LANES];
  logic signed [ACC_W-1:0]  pairRe [OUT_LANES];
  logic signed [ACC_W-1:0]  pairIm [OUT_LANES];
  logic        [ACC_W-1:0]  regRe  [OUT_LANES];
  logic        [ACC_W-1:0]  regIm  [OUT_LANES];

  // operand gather and per-lane interpolation
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [IDX_W-1:0]         lIdx, rIdx;
    logic [SEL_W-1:0]         fSel;
    logic signed [SAMP_W-1:0] lRe, lIm, rRe, rIm;
    logic signed [FRAC_W-1:0] fVal;

    assign lIdx = leftCtl [i*IDX_W +: IDX_W];
    assign rIdx = rightCtl[i*IDX_W +: IDX_W];

    if (i < HALF) begin : g_selLo
      assign fSel = fracSelLo[i*SEL_W +: SEL_W];
    end else begin : g_selHi
      assign fSel = fracSelHi[(i-HALF)*SEL_W +: SEL_W];
    end

    assign lRe  = lutBuf[int'(lIdx)*ENTRY_W          +: SAMP_W];
    assign lIm  = lutBuf[int'(lIdx)*ENTRY_W + SAMP_W +: SAMP_W];
    assign rRe  = lutBuf[int'(rIdx)*ENTRY_W          +: SAMP_W];
    assign rIm  = lutBuf[int'(rIdx)*ENTRY_W + SAMP_W +: SAMP_W];
    assign fVal = fracBuf[int'(fSel)*FRAC_W +: FRAC_W];

    lerp_lane #(
      .SAMP_W(SAMP_W), .FRAC_W(FRAC_W), .SHIFT_W(SHIFT_W), .LANE_W(LANE_W)
    ) u_re (
      .leftVal(lRe), .rightVal(rRe), .frac(fVal), .shiftAmt(shiftAmt), .laneVal(laneRe[i])
    );

    lerp_lane #(
      .SAMP_W(SAMP_W), .FRAC_W(FRAC_W), .SHIFT_W(SHIFT_W), .LANE_W(LANE_W)
    ) u_im (
      .leftVal(lIm), .rightVal(rIm), .frac(fVal), .shiftAmt(shiftAmt), .laneVal(laneIm[i])
    );
  end

  // post-add of neighbouring lanes, sign-extended to the accumulator width
  for (genvar j = 0; j < OUT_LANES; j++) begin : g_pair
    logic signed [ACC_W-1:0] aRe, bRe, aIm, bIm;
    assign aRe = laneRe[2*j];
    assign bRe = laneRe[2*j+1];
    assign aIm = laneIm[2*j];
    assign bIm = laneIm[2*j+1];
    assign pairRe[j] = aRe + bRe;
    assign pairIm[j] = aIm + bIm;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      for (int j = 0; j < OUT_LANES; j++) begin
        regRe[j] <= '0;
        regIm[j] <= '0;
      end
    end else if (strobe.capture) begin
      for (int j = 0; j < OUT_LANES; j++) begin
        regRe[j] <= pairRe[j];
        regIm[j] <= pairIm[j];
      end
    end
  end

  always_comb begin
    for (int j = 0; j < OUT_LANES; j++) begin
      outRe[j*ACC_W +: ACC_W] = regRe[j];
      outIm[j*ACC_W +: ACC_W] = regIm[j];
    end
  end

endmodule

// File: rtl/lerp_pairsum.sv
module lerp_pairsum
  import lerp_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int TAB_DEPTH  = 32,
  parameter int SAMP_W     = 16,
  parameter int FRAC_DEPTH = 16,
  parameter int FRAC_W     = 16,
  parameter int SHIFT_W    = 4,
  parameter int ACC_W      = 48,
  localparam int IDX_W     = $clog2(TAB_DEPTH),
  localparam int SEL_W     = $clog2(FRAC_DEPTH),
  localparam int HALF      = LANES / 2,
  localparam int OUT_LANES = LANES / 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             inValid,
  input  logic [TAB_DEPTH*2*SAMP_W-1:0]    lutBuf,
  input  logic [LANES*IDX_W-1:0]           leftCtl,
  input  logic [LANES*IDX_W-1:0]           rightCtl,
  input  logic [FRAC_DEPTH*FRAC_W-1:0]     fracBuf,
  input  logic [HALF*SEL_W-1:0]            fracSelLo,
  input  logic [HALF*SEL_W-1:0]            fracSelHi,
  input  logic [SHIFT_W-1:0]               shiftAmt,
  output logic                             outValid,
  output logic [OUT_LANES*ACC_W-1:0]       outRe,
  output logic [OUT_LANES*ACC_W-1:0]       outIm
);
  lerpStrobe_t strobe;

  lerp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .strobe(strobe), .outValid(outValid)
  );

  lerp_datapath #(
    .LANES(LANES), .TAB_DEPTH(TAB_DEPTH), .SAMP_W(SAMP_W), .FRAC_DEPTH(FRAC_DEPTH),
    .FRAC_W(FRAC_W), .SHIFT_W(SHIFT_W), .ACC_W(ACC_W)
  ) u_dp (
    .clk(clk), .strobe(strobe), .lutBuf(lutBuf), .leftCtl(leftCtl), .rightCtl(rightCtl),
    .fracBuf(fracBuf), .fracSelLo(fracSelLo), .fracSelHi(fracSelHi), .shiftAmt(shiftAmt),
    .outRe(outRe), .outIm(outIm)
  );

endmodule

// File: rtl/lerp_pairsum_chk.sv
module lerp_pairsum_chk #(
  parameter int TAB_BITS  = 1024,
  parameter int OUT_LANES = 8,
  parameter int ACC_W     = 48,
  parameter int SAMP_W    = 16,
  parameter int FRAC_W    = 16,
  parameter int SHIFT_W   = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       inValid,
  input logic [TAB_BITS-1:0]        lutBuf,
  input logic                       outValid,
  input logic [OUT_LANES*ACC_W-1:0] outRe,
  input logic [OUT_LANES*ACC_W-1:0] outIm
);
  localparam int SHL_W  = SAMP_W + (1 << SHIFT_W) - 1;
  localparam int PROD_W = SAMP_W + 1 + FRAC_W;
  localparam int PAIR_W = ((SHL_W > PROD_W) ? SHL_W : PROD_W) + 2;

  // R1: the cycle after a reset edge shows cleared outputs
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && outRe == '0 && outIm == '0));

  // R2: valid flag trails the input flag by one clock
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (outValid == $past(inValid)));

  // R8: idle input leaves the results untouched
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(inValid)) |-> ($stable(outRe) && $stable(outIm)));

  // R9: an all-zero table yields all-zero sums
  assert_zero_table_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(inValid) && $past(lutBuf) == '0) |-> (outRe == '0 && outIm == '0));

  // R7: upper bits of every output word only repeat the sign
  for (genvar j = 0; j < OUT_LANES; j++) begin : g_sext
    logic [ACC_W-PAIR_W:0] hiRe, hiIm;
    assign hiRe = outRe[j*ACC_W + PAIR_W - 1 +: ACC_W - PAIR_W + 1];
    assign hiIm = outIm[j*ACC_W + PAIR_W - 1 +: ACC_W - PAIR_W + 1];
    assert_sign_ext_R7: assert property (@(posedge clk) disable iff (rst)
      ((&hiRe) || !(|hiRe)) && ((&hiIm) || !(|hiIm)));
  end

endmodule

bind lerp_pairsum lerp_pairsum_chk #(
  .TAB_BITS(TAB_DEPTH*2*SAMP_W), .OUT_LANES(OUT_LANES), .ACC_W(ACC_W),
  .SAMP_W(SAMP_W), .FRAC_W(FRAC_W), .SHIFT_W(SHIFT_W)
) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .lutBuf(lutBuf),
  .outValid(outValid), .outRe(outRe), .outIm(outIm)
);

// File: tb/lerp_pairsum_tb.sv
`timescale 1ns/1ps
module lerp_pairsum_tb;
  localparam int LANES = 16, TAB = 32, OL = 8, ACC = 48;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic                rst, inValid;
  logic [TAB*32-1:0]   lutBuf;
  logic [LANES*5-1:0]  leftCtl, rightCtl;
  logic [16*16-1:0]    fracBuf;
  logic [31:0]         fracSelLo, fracSelHi;
  logic [3:0]          shiftAmt;
  logic                outValid;
  logic [OL*ACC-1:0]   outRe, outIm;

  lerp_pairsum u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .lutBuf(lutBuf), .leftCtl(leftCtl),
    .rightCtl(rightCtl), .fracBuf(fracBuf), .fracSelLo(fracSelLo), .fracSelHi(fracSelHi),
    .shiftAmt(shiftAmt), .outValid(outValid), .outRe(outRe), .outIm(outIm)
  );

  int     nChk = 0, nFail = 0;
  bit     finished = 0;
  longint expRe [OL];
  longint expIm [OL];
  bit     expValid;

  // ---------------- behavioural reference ----------------
  function automatic longint tabVal(int k, int c);
    return longint'($signed(lutBuf[k*32 + c*16 +: 16]));
  endfunction

  function automatic longint laneVal(int i, int c);
    int l = int'(leftCtl[i*5 +: 5]);
    int r = int'(rightCtl[i*5 +: 5]);
    int s = (i < 8) ? int'(fracSelLo[i*4 +: 4]) : int'(fracSelHi[(i-8)*4 +: 4]);
    longint a = tabVal(l, c);
    longint b = tabVal(r, c);
    longint f = longint'($signed(fracBuf[s*16 +: 16]));
    return (a <<< shiftAmt) + (b - a) * f;
  endfunction

  task automatic predict();
    if (rst) begin
      expValid = 1'b0;
      for (int j = 0; j < OL; j++) begin expRe[j] = 0; expIm[j] = 0; end
    end else begin
      expValid = inValid;
      if (inValid)
        for (int j = 0; j < OL; j++) begin
          expRe[j] = laneVal(2*j, 0) + laneVal(2*j+1, 0);
          expIm[j] = laneVal(2*j, 1) + laneVal(2*j+1, 1);
        end
    end
  endtask

  task automatic check(string tag, string what, int lane, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s lane %0d: actual %0d expected %0d", tag, what, lane, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check((tag == "R1") ? "R1" : "R2", "valid", 0, longint'(outValid), longint'(expValid));
    for (int j = 0; j < OL; j++) begin
      check(tag, "re", j, longint'($signed(outRe[j*ACC +: ACC])), expRe[j]);
      check(tag, "im", j, longint'($signed(outIm[j*ACC +: ACC])), expIm[j]);
    end
  endtask

  // predict from the inputs held now, cross the rising edge, compare at the falling edge
  task automatic tick(string tag);
    predict();
    @(negedge clk);
    compare(tag);
  endtask

  // ---------------- stimulus helpers ----------------
  task automatic randTable();
    for (int k = 0; k < TAB; k++) lutBuf[k*32 +: 32] = $urandom;
  endtask

  task automatic randFrac();
    for (int k = 0; k < 16; k++) fracBuf[k*16 +: 16] = 16'($urandom);
  endtask

  function automatic logic [LANES*5-1:0] randIdx();
    logic [LANES*5-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*5 +: 5] = 5'($urandom);
    return v;
  endfunction

  task automatic randAll();
    randTable(); randFrac();
    leftCtl = randIdx(); rightCtl = randIdx();
    fracSelLo = $urandom; fracSelHi = $urandom;
    shiftAmt = 4'($urandom);
  endtask

  // ---------------- sequence ----------------
  initial begin
    rst = 1'b1; inValid = 1'b1;
    randAll();

    // R1: reset ignores valid inputs and clears everything
    for (int n = 0; n < 3; n++) begin tick("R1"); randAll(); end
    rst = 1'b0;

    // R3: distinct table entries, fields crossing word boundaries exercised
    for (int k = 0; k < TAB; k++) lutBuf[k*32 +: 32] = {16'(k*37 - 500), 16'(k*101 - 1500)};
    for (int i = 0; i < LANES; i++) begin
      leftCtl[i*5 +: 5]  = 5'(i*2 + 1);
      rightCtl[i*5 +: 5] = 5'(31 - i);
    end
    randFrac(); fracSelLo = $urandom; fracSelHi = $urandom; shiftAmt = 4'd3;
    tick("R3");
    leftCtl = randIdx(); rightCtl = randIdx();
    tick("R3");

    // R4: every fraction distinct, low and high selector words differ
    for (int k = 0; k < 16; k++) fracBuf[k*16 +: 16] = 16'(k*1000 - 7000);
    fracSelLo = 32'hFEDC_BA98; fracSelHi = 32'h0123_4567; shiftAmt = 4'd0;
    tick("R4");
    fracSelLo = 32'h0000_0000; fracSelHi = 32'hFFFF_FFFF;
    tick("R4");

    // R5: random operands and shifts
    for (int n = 0; n < 24; n++) begin randAll(); tick("R5"); end

    // R6: interleaved layout, right neighbour four entries above the left one
    randTable(); randFrac();
    for (int i = 0; i < LANES; i++) begin
      leftCtl[i*5 +: 5]  = 5'((i % 4) * 8 + i / 4);
      rightCtl[i*5 +: 5] = 5'((i % 4) * 8 + i / 4 + 4);
    end
    fracSelLo = 32'h3210_3210; fracSelHi = 32'h3210_3210; shiftAmt = 4'd15;
    tick("R6");
    shiftAmt = 4'd7;
    tick("R6");

    // R7: full-scale entries of opposite sign at the largest shift
    for (int k = 0; k < TAB; k++)
      lutBuf[k*32 +: 32] = (k % 2 == 0) ? {16'h7FFF, 16'h8000} : {16'h8000, 16'h7FFF};
    for (int i = 0; i < LANES; i++) begin
      leftCtl[i*5 +: 5]  = 5'(2*i);
      rightCtl[i*5 +: 5] = 5'(2*i + 1);
    end
    for (int k = 0; k < 16; k++) fracBuf[k*16 +: 16] = 16'h8000;
    fracSelLo = 32'h0; fracSelHi = 32'h0; shiftAmt = 4'd15;
    tick("R7");
    for (int k = 0; k < 16; k++) fracBuf[k*16 +: 16] = 16'h7FFF;
    tick("R7");
    shiftAmt = 4'd0;
    tick("R7");

    // R8: idle cycles with changing inputs keep the last result
    inValid = 1'b0;
    for (int n = 0; n < 4; n++) begin randAll(); tick("R8"); end

    // R2: valid toggling pattern
    for (int n = 0; n < 12; n++) begin
      inValid = (n % 3 != 1); randAll(); tick("R2");
    end

    // R9: zero table under random maps, fractions and shifts
    inValid = 1'b1;
    for (int n = 0; n < 3; n++) begin randAll(); lutBuf = '0; tick("R9"); end

    // R1: reset in the middle of traffic
    randAll(); tick("R5");
    rst = 1'b1; randAll(); tick("R1");
    rst = 1'b0; randAll(); tick("R5");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

endmodule